// File: doc/BRIEF.md
# Command-Indexed Register Bank with Commit-on-Completion

This block is the register file that sits behind the serial-bus front end of an eight-line I/O expander. A command byte selects one entry of a small map. Six entries are storage: an output-state register and a rising-edge and falling-edge interrupt mask register for each of two banks, normal and suspend. The remaining entries are special. One returns the live pin levels. One returns a fixed identifier byte. Two codes carry no data and instead launch an action: one resamples the address pins, and the other runs a software power-on reset.

Incoming bytes are never applied when they arrive. A write strobe only stages the command and data, and a read strobe, which marks a receive-byte transaction, only stages the command. The effect of a staged transaction happens at the transaction-complete strobe. At that point the register is loaded, or the action is launched. A bank-select input chooses whether the normal or the suspend output-state register drives the pin-output bus.

Top module: `cmdRegBank`

## Requirements
- R1: After hardware reset the normal output-state register (code 08h) and all four mask registers (codes 01h, 02h, 04h, 05h) hold FFh, and the suspend output-state register (code 03h) holds 00h.
- R2: A write strobe changes no register. The staged data is loaded at the first clock edge where the transaction-complete strobe is high, and it is visible from the next cycle on.
- R3: Storage codes map as follows: 01h normal rising mask, 02h normal falling mask, 03h suspend output state, 04h suspend rising mask, 05h suspend falling mask, 08h normal output state. Each committed write shows on its register output and reads back on rdData when cmdCode holds that code.
- R4: With cmdCode at 00h, rdData follows the pinLevels input combinationally.
- R5: With cmdCode at FEh, rdData reads 4Dh. Any code that is not a storage, status or identifier code (06h and 07h included) reads FFh.
- R6: A committed write to a non-storage code (00h, 06h, 07h, FEh or any unused code) leaves all six registers unchanged.
- R7: Committing code 06h raises addrSamplePulse for exactly the one cycle after the commit edge, and raises no irqClearPulse.
- R8: Committing code 07h raises addrSamplePulse and irqClearPulse together for exactly the one cycle after the commit edge. At the end of that cycle every register returns to its R1 value.
- R9: A receive-byte transaction (read strobe, then completion) stores no data. It does launch the action of code 06h or 07h.
- R10: pinOut carries the normal output-state register when bankSel is 0, and the suspend output-state register when bankSel is 1.
- R11: A completion strobe with no staged transaction changes nothing and pulses nothing. A staged transaction takes effect exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hardware reset |
| cmdCode | input | 8 | Command byte from the bus front end |
| wrData | input | 8 | Write data byte |
| wrStrobe | input | 1 | Stage a write of wrData to cmdCode |
| rdStrobe | input | 1 | Stage a receive-byte transaction on cmdCode |
| xferDone | input | 1 | Transaction-complete strobe; commits the staged transaction |
| pinLevels | input | 8 | Present I/O pin levels |
| bankSel | input | 1 | 0 selects the normal bank, 1 the suspend bank |
| rdData | output | 8 | Read value for cmdCode |
| pinOut | output | 8 | Output state of the selected bank |
| normOut | output | 8 | Normal output-state register |
| normRiseMask | output | 8 | Normal rising-edge mask |
| normFallMask | output | 8 | Normal falling-edge mask |
| suspOut | output | 8 | Suspend output-state register |
| suspRiseMask | output | 8 | Suspend rising-edge mask |
| suspFallMask | output | 8 | Suspend falling-edge mask |
| addrSamplePulse | output | 1 | One-cycle request to resample the address pins |
| irqClearPulse | output | 1 | One-cycle request to clear pending interrupts |

## Verification
The bench writes every one of the 256 command codes, each with distinct data. Between staging and completion it compares all six registers, which separates deferred commit from immediate loading. After commit it compares them again, which separates storage codes from ignored ones. After each commit it reads the code back with new pin levels, so that live status, the identifier, stored values and the FFh default cannot be mistaken for one another. Receive-byte transactions, empty completion strobes and both bank-select values are each tried separately. These show that reads never store, that actions fire once and in the right cycle, and that the output mux follows the bank select.

// File: rtl/cmdbank_pkg.sv
package cmdbank_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 6;

  // storage slot indices
  localparam int SLOT_NRISE = 0;
  localparam int SLOT_NFALL = 1;
  localparam int SLOT_SOUT  = 2;
  localparam int SLOT_SRISE = 3;
  localparam int SLOT_SFALL = 4;
  localparam int SLOT_NOUT  = 5;

  localparam logic [BYTE_W-1:0] CMD_STATUS   = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_ADDR_SMP = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_SOFT_POR = 8'h07;
  localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'hFE;

  // command code served by each storage slot
  function automatic logic [BYTE_W-1:0] slotCode(input int slot);
    case (slot)
      SLOT_NRISE: slotCode = 8'h01;
      SLOT_NFALL: slotCode = 8'h02;
      SLOT_SOUT:  slotCode = 8'h03;
      SLOT_SRISE: slotCode = 8'h04;
      SLOT_SFALL: slotCode = 8'h05;
      default:    slotCode = 8'h08;
    endcase
  endfunction

  // power-on value of each storage slot
  function automatic logic [BYTE_W-1:0] slotResetVal(input int slot);
    slotResetVal = (slot == SLOT_SOUT) ? '0 : '1;
  endfunction

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic [BYTE_W-1:0]   data;
    logic                swReset;
  } bankStrb_t;

endpackage

// File: rtl/cmdbank_ctrl.sv
module cmdbank_ctrl
  import cmdbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] cmdCode,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic              xferDone,
  output bankStrb_t         strb,
  output logic              addrSamplePulse,
  output logic              irqClearPulse
);

  logic [BYTE_W-1:0] pendCmd;
  logic [BYTE_W-1:0] pendData;
  logic              pendWr;
  logic              pendAct;
  logic              swRstQ;
  logic              sampleQ;
  logic              commit;
  logic              isActCode;

  assign commit    = xferDone & pendAct;
  assign isActCode = (pendCmd == CMD_ADDR_SMP) || (pendCmd == CMD_SOFT_POR);

  // staging of the transaction; commit clears before a new stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCmd  <= '0;
      pendData <= '0;
      pendWr   <= 1'b0;
      pendAct  <= 1'b0;
    end else begin
      if (commit) begin
        pendWr  <= 1'b0;
        pendAct <= 1'b0;
      end
      if (wrStrobe) begin
        pendCmd  <= cmdCode;
        pendData <= wrData;
        pendWr   <= 1'b1;
        pendAct  <= 1'b1;
      end else if (rdStrobe) begin
        pendCmd  <= cmdCode;
        pendWr   <= 1'b0;
        pendAct  <= 1'b1;
      end
    end
  end

  // actions launch in the cycle after the commit edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swRstQ  <= 1'b0;
      sampleQ <= 1'b0;
    end else begin
      swRstQ  <= commit & (pendCmd == CMD_SOFT_POR);
      sampleQ <= commit & isActCode;
    end
  end

  // per-slot load decode
  logic [NUM_REGS-1:0] loadVec;
  for (genvar s = 0; s < NUM_REGS; s++) begin : g_dec
    assign loadVec[s] = commit & pendWr & (pendCmd == slotCode(s));
  end

  always_comb begin
    strb.load    = loadVec;
    strb.data    = pendData;
    strb.swReset = swRstQ;
  end

  assign addrSamplePulse = sampleQ;
  assign irqClearPulse   = swRstQ;

  AST_LOAD_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.load) |-> xferDone);  // R2
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.load));  // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqClearPulse |=> !irqClearPulse);  // R8
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irqClearPulse |-> $past(xferDone));  // R8
  AST_IRQ_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    irqClearPulse |-> addrSamplePulse);  // R8
  AST_SAMPLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    addrSamplePulse |-> $past(xferDone));  // R7
  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    addrSamplePulse |=> !addrSamplePulse);  // R11

endmodule

// File: rtl/cmdbank_dpath.sv
module cmdbank_dpath
  import cmdbank_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ID_VALUE      = 8'h4D,
  parameter logic [BYTE_W-1:0] UNKNOWN_VALUE = 8'hFF
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  bankStrb_t                      strb,
  input  logic [BYTE_W-1:0]              cmdCode,
  input  logic [BYTE_W-1:0]              pinLevels,
  input  logic                           bankSel,
  output logic [NUM_REGS-1:0][BYTE_W-1:0] regQ,
  output logic [BYTE_W-1:0]              rdData,
  output logic [BYTE_W-1:0]              pinOut
);

  for (genvar s = 0; s < NUM_REGS; s++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN || strb.swReset) regQ[s] <= slotResetVal(s);
      else if (strb.load[s])     regQ[s] <= strb.data;
    end

    AST_SWRST_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
      strb.swReset |=> (regQ[s] == slotResetVal(s)));  // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.load[s] && !strb.swReset) |=> $stable(regQ[s]));  // R6
  end

  // command-indexed read mux
  always_comb begin
    rdData = UNKNOWN_VALUE;
    if (cmdCode == CMD_STATUS)     rdData = pinLevels;
    else if (cmdCode == CMD_IDENT) rdData = ID_VALUE;
    for (int s = 0; s < NUM_REGS; s++)
      if (cmdCode == slotCode(s)) rdData = regQ[s];
  end

  assign pinOut = bankSel ? regQ[SLOT_SOUT] : regQ[SLOT_NOUT];

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_STATUS) |-> (rdData == pinLevels));  // R4

endmodule

// File: rtl/cmdRegBank.sv
module cmdRegBank
  import cmdbank_pkg::*;
#(
  parameter logic [7:0] ID_VALUE      = 8'h4D,
  parameter logic [7:0] UNKNOWN_VALUE = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cmdCode,
  input  logic [7:0] wrData,
  input  logic       wrStrobe,
  input  logic       rdStrobe,
  input  logic       xferDone,
  input  logic [7:0] pinLevels,
  input  logic       bankSel,
  output logic [7:0] rdData,
  output logic [7:0] pinOut,
  output logic [7:0] normOut,
  output logic [7:0] normRiseMask,
  output logic [7:0] normFallMask,
  output logic [7:0] suspOut,
  output logic [7:0] suspRiseMask,
  output logic [7:0] suspFallMask,
  output logic       addrSamplePulse,
  output logic       irqClearPulse
);

  bankStrb_t strb;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regQ;

  cmdbank_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .cmdCode         (cmdCode),
    .wrData          (wrData),
    .wrStrobe        (wrStrobe),
    .rdStrobe        (rdStrobe),
    .xferDone        (xferDone),
    .strb            (strb),
    .addrSamplePulse (addrSamplePulse),
    .irqClearPulse   (irqClearPulse)
  );

  cmdbank_dpath #(
    .ID_VALUE      (ID_VALUE),
    .UNKNOWN_VALUE (UNKNOWN_VALUE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmdCode   (cmdCode),
    .pinLevels (pinLevels),
    .bankSel   (bankSel),
    .regQ      (regQ),
    .rdData    (rdData),
    .pinOut    (pinOut)
  );

  assign normRiseMask = regQ[SLOT_NRISE];
  assign normFallMask = regQ[SLOT_NFALL];
  assign suspOut      = regQ[SLOT_SOUT];
  assign suspRiseMask = regQ[SLOT_SRISE];
  assign suspFallMask = regQ[SLOT_SFALL];
  assign normOut      = regQ[SLOT_NOUT];

  AST_NO_COMMIT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!xferDone && !irqClearPulse) |=> $stable(normOut) && $stable(suspOut));  // R2

endmodule

// File: tb/tb_cmdRegBank.sv
`timescale 1ns/1ps
module tb_cmdRegBank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cmdCode = '0, wrData = '0, pinLevels = '0;
  logic       wrStrobe = 1'b0, rdStrobe = 1'b0, xferDone = 1'b0, bankSel = 1'b0;
  logic [7:0] rdData, pinOut, normOut, normRiseMask, normFallMask;
  logic [7:0] suspOut, suspRiseMask, suspFallMask;
  logic       addrSamplePulse, irqClearPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // model, slot order: nRise, nFall, sOut, sRise, sFall, nOut
  logic [7:0] m [6];

  always #2 clk = ~clk;

  cmdRegBank dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelPor();
    for (int i = 0; i < 6; i++) m[i] = (i == 2) ? 8'h00 : 8'hFF;
  endtask

  function automatic int slotOf(input logic [7:0] c);
    case (c)
      8'h01: slotOf = 0;
      8'h02: slotOf = 1;
      8'h03: slotOf = 2;
      8'h04: slotOf = 3;
      8'h05: slotOf = 4;
      8'h08: slotOf = 5;
      default: slotOf = -1;
    endcase
  endfunction

  function automatic logic [47:0] regsAct();
    regsAct = {normRiseMask, normFallMask, suspOut, suspRiseMask, suspFallMask, normOut};
  endfunction

  function automatic logic [47:0] regsExp();
    regsExp = {m[0], m[1], m[2], m[3], m[4], m[5]};
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] c);
    if (c == 8'h00) expRead = pinLevels;
    else if (c == 8'hFE) expRead = 8'h4D;
    else if (slotOf(c) >= 0) expRead = m[slotOf(c)];
    else expRead = 8'hFF;
  endfunction

  // stage a transaction (write or receive-byte), then complete it
  task automatic runXfer(input bit isWr, input logic [7:0] c, input logic [7:0] d,
                         input string req, output bit smp, output bit irq);
    @(negedge clk);
    cmdCode = c; wrData = d; wrStrobe = isWr; rdStrobe = !isWr;
    @(negedge clk);
    wrStrobe = 1'b0; rdStrobe = 1'b0;
    chk({req, " R2 staged no change"}, regsAct(), regsExp());
    chk({req, " R11 no early pulse"}, {addrSamplePulse, irqClearPulse}, 2'b00);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    smp = addrSamplePulse; irq = irqClearPulse;
  endtask

  task automatic checkRead(input logic [7:0] c, input string req);
    cmdCode = c;
    #0.5;
    chk(req, rdData, expRead(c));
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit smp, irq;
    modelPor();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset values", regsAct(), regsExp());
    chk("R1 no pulses", {addrSamplePulse, irqClearPulse}, 2'b00);

    // sweep over all command codes
    for (int c = 0; c < 256; c++) begin
      logic [7:0] d;
      d = 8'(c) ^ 8'hA5;
      runXfer(1'b1, 8'(c), d, "R2", smp, irq);
      if (c == 7) begin
        chk("R8 pulses at soft reset", {smp, irq}, 2'b11);
        @(negedge clk);
        modelPor();
        chk("R8 registers restored", regsAct(), regsExp());
        chk("R8 pulses one cycle", {addrSamplePulse, irqClearPulse}, 2'b00);
      end else begin
        if (slotOf(8'(c)) >= 0) m[slotOf(8'(c))] = d;
        chk((slotOf(8'(c)) >= 0) ? "R3 stored" : "R6 ignored", regsAct(), regsExp());
        chk((c == 6) ? "R7 sample pulse" : "R7 no pulse", {smp, irq}, {(c == 6), 1'b0});
        @(negedge clk);
        chk("R7 pulse ends", {addrSamplePulse, irqClearPulse}, 2'b00);
      end
      pinLevels = 8'(c * 37 + 11);
      checkRead(8'(c), "R3 R4 R5 read map");
    end

    // R4 live status
    for (int p = 0; p < 8; p++) begin
      pinLevels = 8'(1 << p);
      checkRead(8'h00, "R4 status live");
    end
    checkRead(8'hFE, "R5 identifier");
    checkRead(8'h07, "R5 action code reads default");

    // R10 bank select
    runXfer(1'b1, 8'h08, 8'h3C, "R10", smp, irq); m[5] = 8'h3C;
    runXfer(1'b1, 8'h03, 8'hC3, "R10", smp, irq); m[2] = 8'hC3;
    bankSel = 1'b0; #0.5; chk("R10 normal bank", pinOut, 8'h3C);
    bankSel = 1'b1; #0.5; chk("R10 suspend bank", pinOut, 8'hC3);
    bankSel = 1'b0;

    // R9 receive-byte stores nothing, launches actions
    wrData = 8'h99;
    runXfer(1'b0, 8'h08, 8'h99, "R9", smp, irq);
    chk("R9 read stores nothing", regsAct(), regsExp());
    chk("R9 no pulse on storage read", {smp, irq}, 2'b00);
    runXfer(1'b0, 8'h06, 8'h99, "R9", smp, irq);
    chk("R9 receive-byte sample", {smp, irq}, 2'b10);
    chk("R9 sample leaves registers", regsAct(), regsExp());

    // R11 empty completion and single effect
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    chk("R11 empty completion pulses", {addrSamplePulse, irqClearPulse}, 2'b00);
    chk("R11 empty completion regs", regsAct(), regsExp());
    runXfer(1'b1, 8'h01, 8'h12, "R11", smp, irq); m[0] = 8'h12;
    @(negedge clk); xferDone = 1'b1; wrData = 8'h77;
    @(negedge clk); xferDone = 1'b0;
    chk("R11 single commit", regsAct(), regsExp());

    runXfer(1'b0, 8'h07, 8'h00, "R9", smp, irq);
    chk("R9 receive-byte soft reset pulses", {smp, irq}, 2'b11);
    @(negedge clk);
    modelPor();
    chk("R9 R8 soft reset via read", regsAct(), regsExp());

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule